// File: doc/BRIEF.md
# High-Address Latch and Region Select Decoder

This block sits beside a CPU whose address bus carries the high and low address bytes on the same pins at different times. While a timing strobe from the CPU is high, the six shared address lines pass straight through a transparent hold stage. When the strobe falls, the value present at the last clock edge with the strobe high is kept. Four of the held lines leave the block as address bits 8 to 11. The other two choose one of four 4K-byte memory regions, so one instance covers 16K bytes.

The region choice leaves the block as four active-low select lines. A chip-enable input, active low, qualifies them. A build-time mode can also require a memory-read or memory-write strobe to be active before any select goes low. Memories without an output enable then stay off the data bus while the CPU drives it. The qualification is combinational and follows the enable and strobe inputs at once. The held address bits ignore all of these inputs.

Top module: `hiaddr_latch_dec`

## Requirements
- R1: While `strobe` is high, `hi_addr` equals `mux_addr[3:0]` in the same cycle, and the region used for decoding is `mux_addr[5:4]`.
- R2: While `strobe` is low, the block keeps the `mux_addr` value sampled at the last rising clock edge at which `strobe` was high. Changes on `mux_addr` have no effect during that time.
- R3: Held bit `mux_addr[i]` drives `hi_addr[i]` for i = 0..3. These are system address bits 8 to 11.
- R4: When the selects are enabled, held region value k (from `mux_addr[5:4]`, k = 0..3) drives `cs_n[k]` low and the other three `cs_n` bits high.
- R5: When `ce_n` is 1, `cs_n` is 4'b1111.
- R6: With `MODE = GATE_CE_STROBES` (the default), the selects are enabled only when `ce_n` is 0 and at least one of `rd_n` or `wr_n` is 0. If both are 1, `cs_n` is 4'b1111.
- R7: With `MODE = GATE_CE_ONLY`, `ce_n` = 0 alone enables the selects, and `rd_n` and `wr_n` have no effect.
- R8: `hi_addr` does not depend on `ce_n`, `rd_n` or `wr_n`.
- R9: `cs_n` changes in the same cycle as `ce_n`, `rd_n` or `wr_n`, without any strobe activity.
- R10: Reset (`rst_n` low) clears the held value to zero. After reset with `strobe` low, `hi_addr` is 4'h0 and region 0 is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the shared address lines |
| rst_n | input | 1 | Active-low synchronous reset of the held value |
| strobe | input | 1 | High: hold stage transparent. Low: hold |
| mux_addr | input | 6 | Shared address lines: [3:0] address bits, [5:4] region |
| ce_n | input | 1 | Active-low chip enable for the selects |
| rd_n | input | 1 | Active-low memory-read strobe (gated mode) |
| wr_n | input | 1 | Active-low memory-write strobe (gated mode) |
| hi_addr | output | 4 | Held address bits 8 to 11 |
| cs_n | output | 4 | Active-low one-of-four region selects |

## Verification
While `strobe` is high, `hi_addr` and `cs_n` follow `mux_addr` in the same cycle. Changes on `ce_n`, `rd_n` and `wr_n` also reach `cs_n` in the same cycle. The held value takes one rising edge with `strobe` high to load. The bench therefore drives every input at the falling clock edge and samples 1 ns later. Before it drops `strobe`, the bench keeps the address stable across one rising edge. It then scrambles `mux_addr` in the same step that `strobe` falls, so any leak of live data into the held path shows up at the next sample.

// File: rtl/hiaddr_pkg.sv
package hiaddr_pkg;

  // Select-qualification variants chosen at build time.
  typedef enum logic {
    GATE_CE_ONLY    = 1'b0,
    GATE_CE_STROBES = 1'b1
  } gate_mode_e;

  // The selects may go low only when this returns 1.
  function automatic logic select_enable(gate_mode_e mode, logic ce_n,
                                         logic rd_n, logic wr_n);
    logic strobe_ok;
    strobe_ok = (mode == GATE_CE_ONLY) ? 1'b1 : (~rd_n | ~wr_n);
    return ~ce_n & strobe_ok;
  endfunction

endpackage

// File: rtl/hiaddr_capture.sv
module hiaddr_capture #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)      held <= '0;
    else if (strobe) held <= d;
  end

  // Transparent while the strobe is high, otherwise the held copy.
  assign q = strobe ? d : held;
endmodule

// File: rtl/hiaddr_decode.sv
module hiaddr_decode #(
  parameter int SEL_W  = 2,
  localparam int NUM_CS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] raw_n
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    assign raw_n[g] = (sel != SEL_W'(g));
  end
endmodule

// File: rtl/hiaddr_gate.sv
module hiaddr_gate #(
  parameter int                   NUM_CS = 4,
  parameter hiaddr_pkg::gate_mode_e MODE = hiaddr_pkg::GATE_CE_STROBES
) (
  input  logic [NUM_CS-1:0] raw_n,
  input  logic              ce_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              en,
  output logic [NUM_CS-1:0] cs_n
);
  assign en   = hiaddr_pkg::select_enable(MODE, ce_n, rd_n, wr_n);
  assign cs_n = en ? raw_n : '1;
endmodule

// File: rtl/hiaddr_latch_dec.sv
module hiaddr_latch_dec #(
  parameter int                     HI_W  = 4,
  parameter int                     SEL_W = 2,
  parameter hiaddr_pkg::gate_mode_e MODE  = hiaddr_pkg::GATE_CE_STROBES,
  localparam int                    IN_W   = HI_W + SEL_W,
  localparam int                    NUM_CS = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [IN_W-1:0]   mux_addr,
  input  logic              ce_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [HI_W-1:0]   hi_addr,
  output logic [NUM_CS-1:0] cs_n
);
  // Named internal events, visible to the bound checker.
  logic [IN_W-1:0]   latched_w;
  logic [SEL_W-1:0]  region_w;
  logic [NUM_CS-1:0] raw_n_w;
  logic              sel_en_w;

  hiaddr_capture #(.W(IN_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .d(mux_addr), .q(latched_w)
  );

  assign hi_addr  = latched_w[HI_W-1:0];
  assign region_w = latched_w[IN_W-1:HI_W];

  hiaddr_decode #(.SEL_W(SEL_W)) u_decode (
    .sel(region_w), .raw_n(raw_n_w)
  );

  hiaddr_gate #(.NUM_CS(NUM_CS), .MODE(MODE)) u_gate (
    .raw_n(raw_n_w), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .en(sel_en_w), .cs_n(cs_n)
  );
endmodule

// File: rtl/hiaddr_latch_dec_chk.sv
module hiaddr_latch_dec_chk #(
  parameter int                     HI_W  = 4,
  parameter int                     SEL_W = 2,
  parameter hiaddr_pkg::gate_mode_e MODE  = hiaddr_pkg::GATE_CE_STROBES,
  localparam int                    IN_W   = HI_W + SEL_W,
  localparam int                    NUM_CS = 1 << SEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe,
  input logic [IN_W-1:0]   mux_addr,
  input logic              ce_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [HI_W-1:0]   hi_addr,
  input logic [NUM_CS-1:0] cs_n
);
  // Goes high one cycle after reset, so $past never reaches into reset.
  logic settled;
  always_ff @(posedge clk) begin
    if (!rst_n) settled <= 1'b0;
    else        settled <= 1'b1;
  end

  logic ports_enable;
  assign ports_enable = !ce_n && (MODE == hiaddr_pkg::GATE_CE_ONLY || !rd_n || !wr_n);

  assert_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> hi_addr == mux_addr[HI_W-1:0]);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !strobe) |-> $stable(hi_addr));

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ports_enable |-> $countones(~cs_n) == 1);

  assert_ce_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> cs_n == '1);

  assert_strobe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == hiaddr_pkg::GATE_CE_STROBES && rd_n && wr_n) |-> cs_n == '1);

  assert_never_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
endmodule

bind hiaddr_latch_dec hiaddr_latch_dec_chk #(
  .HI_W(HI_W), .SEL_W(SEL_W), .MODE(MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .mux_addr(mux_addr),
  .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n), .hi_addr(hi_addr), .cs_n(cs_n)
);

// File: tb/hiaddr_latch_dec_tb.sv
module hiaddr_latch_dec_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [5:0] mux_addr = '0;
  logic       ce_n = 1'b0, rd_n = 1'b0, wr_n = 1'b1;
  logic [3:0] hi_addr, cs_n, hi_open, cs_open;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hiaddr_latch_dec u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .mux_addr(mux_addr),
    .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n), .hi_addr(hi_addr), .cs_n(cs_n)
  );

  hiaddr_latch_dec #(.MODE(hiaddr_pkg::GATE_CE_ONLY)) u_dut_open (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .mux_addr(mux_addr),
    .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n), .hi_addr(hi_open), .cs_n(cs_open)
  );

  // {address, ce_n rd_n wr_n, expected hi_addr, expected cs_n (gated mode)}
  localparam logic [16:0] VEC [0:7] = '{
    {6'b000101, 3'b001, 4'h5, 4'b1110},
    {6'b011010, 3'b010, 4'hA, 4'b1101},
    {6'b101111, 3'b000, 4'hF, 4'b1011},
    {6'b110000, 3'b001, 4'h0, 4'b0111},
    {6'b111001, 3'b101, 4'h9, 4'b1111},
    {6'b100011, 3'b011, 4'h3, 4'b1111},
    {6'b010110, 3'b111, 4'h6, 4'b1111},
    {6'b001100, 3'b010, 4'hC, 4'b1110}
  };

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Ungated expectation: chip enable alone, read/write ignored.
  function automatic logic [3:0] open_cs(logic [1:0] region, logic ce);
    case ({ce, region})
      3'b000:  return 4'b1110;
      3'b001:  return 4'b1101;
      3'b010:  return 4'b1011;
      3'b011:  return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic load(logic [5:0] a);
    @(negedge clk);
    strobe = 1'b1; mux_addr = a;
    #1;
    check("R1 transparent hi_addr", hi_addr, a[3:0]);
    @(negedge clk);
    strobe = 1'b0; mux_addr = ~a;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset with a non-zero address on the lines and strobe high.
    strobe = 1'b1; mux_addr = 6'b111111;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 reset hi_addr", hi_addr, 4'h0);
    check("R10 reset cs_n region 0", cs_n, 4'b1110);

    foreach (VEC[i]) begin
      load(VEC[i][16:11]);
      ce_n = VEC[i][10]; rd_n = VEC[i][9]; wr_n = VEC[i][8];
      #1;
      check("R2/R3 held hi_addr", hi_addr, VEC[i][7:4]);
      check("R4/R5/R6 gated cs_n", cs_n, VEC[i][3:0]);
      check("R7 ungated cs_n", cs_open, open_cs(VEC[i][16:15], VEC[i][10]));
    end

    // R2: scramble the lines for several cycles while strobe is low.
    load(6'b100110);
    ce_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); mux_addr = 6'(k * 13 + 1);
      #1;
      check("R2 hold under address churn hi", hi_addr, 4'h6);
      check("R2 hold under address churn cs", cs_n, 4'b1011);
    end

    // R1: region follows the live lines while strobe is high.
    @(negedge clk); strobe = 1'b1; mux_addr = 6'b110001;
    #1;
    check("R1 transparent region", cs_n, 4'b0111);
    mux_addr = 6'b010010;
    #1;
    check("R1 transparent mid-cycle hi", hi_addr, 4'h2);
    check("R1 transparent mid-cycle cs", cs_n, 4'b1101);
    @(negedge clk); strobe = 1'b0; mux_addr = 6'b000000;

    // R9 and R8: gating inputs act at once, address bits untouched.
    #1;
    check("R9 baseline cs", cs_n, 4'b1101);
    ce_n = 1'b1; #1;
    check("R9 ce_n rise same cycle", cs_n, 4'b1111);
    check("R8 hi_addr ignores ce_n", hi_addr, 4'h2);
    ce_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; #1;
    check("R6 both strobes idle", cs_n, 4'b1111);
    check("R7 ungated ignores idle strobes", cs_open, 4'b1101);
    check("R8 hi_addr ignores rd/wr", hi_addr, 4'h2);
    wr_n = 1'b0; #1;
    check("R9 wr_n fall same cycle", cs_n, 4'b1101);
    check("R3 ungated hi_addr matches", hi_open, 4'h2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule